// File: doc/BRIEF.md
# Register-Exchange Survivor Memory with State Purging

This block keeps the survivor sequences of a 64-state trellis decoder using the register-exchange scheme. Each state owns one row that holds the last 42 decoded symbols of the best path ending in that state. On every accepted trellis step, each live row copies the row of the predecessor picked by its decision, shifts it by one entry, and writes the symbol that the transition implies. The symbol pushed out of the row belonging to a chosen live state becomes the decoded output.

The surrounding path-metric logic may purge any state in any step, so no state is guaranteed to stay alive. Rows of purged states keep their contents in that step. The caller supplies a per-state live mask and the index of one live state, and the decoder reads its output through that index. The trellis follows a shift-register encoder whose leftmost cell is the state MSB. New symbols enter from that side.

Top module: `survivor_regx`

## Requirements
- R1: After synchronous reset `out_valid` is 0, `out_sym` is 0, every row is cleared and the fill count is zero.
- R2: A cycle with `in_valid` low changes no row and no fill count, and `out_valid` is 0 in the following cycle.
- R3: For state `s`, a decision `d` taken from `dec_bits[s*2 +: 2]` selects the predecessor `{s[3:0], d}` as the source row.
- R4: The symbol written as the newest entry of row `s` is the top two state bits `s[5:4]`. Entries move one place toward the oldest position on each update.
- R5: A row whose `act_mask` bit is 0 in an accepted step keeps its contents unchanged.
- R6: In an accepted step, `out_sym` takes the oldest entry of the source row feeding state `act_idx` (the entry being pushed out), one cycle later.
- R7: `out_valid` is 1 in the cycle after an accepted step only when at least 42 steps had been accepted before it. On a clean trellis path this makes the output equal to the symbol supplied 42 accepted steps earlier.
- R8: Asserting reset in the middle of operation restarts filling, so the next 42 accepted steps produce no valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Step strobe; qualifies all other inputs |
| dec_bits | input | 128 | Two-bit predecessor choice per state, state s at bits [2s+1:2s] |
| act_mask | input | 64 | Live flag per state; 0 means purged |
| act_idx | input | 6 | Index of a live state used for readout |
| out_valid | output | 1 | Decoded symbol valid |
| out_sym | output | 2 | Decoded symbol |

## Verification
Rows update on the clock edge that accepts a step. `out_sym` and `out_valid` are registered from that same edge, so every result is due exactly one edge after its stimulus. The bench applies each step on a falling edge and reads the outputs on the next falling edge. It compares them there against a behavioural model that sees the same mask and decisions, and on encoder-consistent paths against the symbol history delayed by 42 accepted steps. Idle cycles and purged rows are checked through later outputs, which would diverge if any held row had changed.

// File: rtl/svm_pkg.sv
package svm_pkg;
    localparam int STATE_BITS = 6;
    localparam int SYM_W      = 2;
    localparam int SURV_LEN   = 42;
    localparam int N_STATES   = 1 << STATE_BITS;
    localparam int ROW_W      = SURV_LEN * SYM_W;

    typedef enum logic {
        PH_FILLING = 1'b0,
        PH_FILLED  = 1'b1
    } fill_phase_e;
endpackage

// File: rtl/svm_fill.sv
module svm_fill #(
    parameter int SURV_LEN = svm_pkg::SURV_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic full
);
    import svm_pkg::*;
    localparam int CW = $clog2(SURV_LEN + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SURV_LEN);

    logic [CW-1:0] cnt_q;
    fill_phase_e   phase;

    assign phase = (cnt_q == LIMIT) ? PH_FILLED : PH_FILLING;
    assign full  = (phase == PH_FILLED);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (adv && phase == PH_FILLING)
            cnt_q <= cnt_q + 1'b1;
    end

    // R7: count never passes the survivor length
    always_ff @(posedge clk) begin
        if (!rst) assert_fill_cap_R7: assert (cnt_q <= LIMIT);
    end

    // R2: idle cycles leave the count alone
    assert_idle_count_R2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));
endmodule

// File: rtl/svm_pred_sel.sv
module svm_pred_sel #(
    parameter int STATE_BITS = svm_pkg::STATE_BITS,
    parameter int SYM_W      = svm_pkg::SYM_W,
    parameter int SURV_LEN   = svm_pkg::SURV_LEN,
    parameter int STATE_IDX  = 0
) (
    input  logic [SURV_LEN*SYM_W-1:0] rows_i [1<<STATE_BITS],
    input  logic [SYM_W-1:0]          dec_i,
    output logic [SURV_LEN*SYM_W-1:0] nxt_o,
    output logic [SYM_W-1:0]          drop_o
);
    localparam int ROW_W = SURV_LEN * SYM_W;
    localparam logic [STATE_BITS-1:0] ST = STATE_BITS'(STATE_IDX);
    localparam logic [SYM_W-1:0] NEW_SYM = ST[STATE_BITS-1 -: SYM_W];

    logic [STATE_BITS-1:0] pred;
    logic [ROW_W-1:0]      src;

    always_comb begin
        pred   = {ST[STATE_BITS-SYM_W-1:0], dec_i};
        src    = rows_i[pred];
        nxt_o  = {src[ROW_W-SYM_W-1:0], NEW_SYM};
        drop_o = src[ROW_W-1 -: SYM_W];
    end
endmodule

// File: rtl/svm_row.sv
module svm_row #(
    parameter int ROW_W = svm_pkg::ROW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] d_i,
    output logic [ROW_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (load)
            q_o <= d_i;
    end

    // R5: a row that is not loaded keeps its survivor
    assert_purged_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q_o));
endmodule

// File: rtl/survivor_regx.sv
module survivor_regx #(
    parameter int STATE_BITS = svm_pkg::STATE_BITS,
    parameter int SYM_W      = svm_pkg::SYM_W,
    parameter int SURV_LEN   = svm_pkg::SURV_LEN
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                in_valid,
    input  logic [(1<<STATE_BITS)*SYM_W-1:0]    dec_bits,
    input  logic [(1<<STATE_BITS)-1:0]          act_mask,
    input  logic [STATE_BITS-1:0]               act_idx,
    output logic                                out_valid,
    output logic [SYM_W-1:0]                    out_sym
);
    localparam int NS    = 1 << STATE_BITS;
    localparam int ROW_W = SURV_LEN * SYM_W;

    logic [ROW_W-1:0] rows_q   [NS];
    logic [ROW_W-1:0] nxt_rows [NS];
    logic [SYM_W-1:0] drop_sym [NS];
    logic             full;

    for (genvar s = 0; s < NS; s++) begin : g_state
        svm_pred_sel #(
            .STATE_BITS(STATE_BITS), .SYM_W(SYM_W),
            .SURV_LEN(SURV_LEN), .STATE_IDX(s)
        ) u_sel (
            .rows_i (rows_q),
            .dec_i  (dec_bits[s*SYM_W +: SYM_W]),
            .nxt_o  (nxt_rows[s]),
            .drop_o (drop_sym[s])
        );
        svm_row #(.ROW_W(ROW_W)) u_row (
            .clk  (clk),
            .rst  (rst),
            .load (in_valid & act_mask[s]),
            .d_i  (nxt_rows[s]),
            .q_o  (rows_q[s])
        );
    end

    svm_fill #(.SURV_LEN(SURV_LEN)) u_fill (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_valid),
        .full (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
        end else begin
            out_valid <= in_valid & full;
            if (in_valid)
                out_sym <= drop_sym[act_idx];
        end
    end

    // R2: no output after an idle cycle
    assert_idle_no_output_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7: no output while the rows are still filling
    assert_no_early_output_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !full) |=> !out_valid);

    // R6: output symbol only moves on accepted steps
    assert_sym_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sym));
endmodule

// File: tb/survivor_regx_tb.sv
module survivor_regx_tb;
    localparam int SB  = 6;
    localparam int W   = 2;
    localparam int L   = 42;
    localparam int NS  = 1 << SB;
    localparam int RW  = L * W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [NS*W-1:0]   dec_bits = '0;
    logic [NS-1:0]     act_mask = '0;
    logic [SB-1:0]     act_idx = '0;
    logic              out_valid;
    logic [W-1:0]      out_sym;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [RW-1:0] m_rows [NS];
    int            m_cnt;
    logic [W-1:0]  m_sym;
    logic          m_valid;

    logic [SB-1:0] path_st;
    int            acc;
    logic [W-1:0]  u_hist [8192];

    always #5 clk = ~clk;

    survivor_regx u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dec_bits(dec_bits),
        .act_mask(act_mask), .act_idx(act_idx),
        .out_valid(out_valid), .out_sym(out_sym)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < NS; s++) m_rows[s] = '0;
        m_cnt = 0; m_sym = '0; m_valid = 1'b0;
        path_st = '0; acc = 0;
    endtask

    // one step: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic v, input logic [NS*W-1:0] dec,
                        input logic [NS-1:0] mask, input logic [SB-1:0] idx,
                        input string tag);
        logic [RW-1:0] nr [NS];
        in_valid = v; dec_bits = dec; act_mask = mask; act_idx = idx;
        @(posedge clk);
        if (v) begin
            for (int s = 0; s < NS; s++) begin
                logic [SB-1:0] st;
                logic [SB-1:0] pr;
                st = SB'(s);
                pr = {st[SB-W-1:0], dec[s*W +: W]};               // R3
                nr[s] = {m_rows[pr][RW-W-1:0], st[SB-1 -: W]};    // R4
                if (st == idx) m_sym = m_rows[pr][RW-1 -: W];     // R6
            end
            for (int s = 0; s < NS; s++)
                if (mask[s]) m_rows[s] = nr[s];                   // R5
            m_valid = (m_cnt >= L);                               // R7
            if (m_cnt < L) m_cnt++;
        end else begin
            m_valid = 1'b0;                                       // R2
        end
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " out_valid"}, int'(out_valid), int'(m_valid));
        if (m_valid) check({tag, " out_sym"}, int'(out_sym), int'(m_sym));
    endtask

    function automatic logic [NS*W-1:0] rand_dec();
        logic [NS*W-1:0] d;
        for (int i = 0; i < NS*W; i += 32) d[i +: 32] = $urandom;
        return d;
    endfunction

    // advance the encoder path one symbol with purges and random decoys
    task automatic path_step(input int purge_pct, input string tag);
        logic [W-1:0]    u;
        logic [SB-1:0]   nx;
        logic [NS*W-1:0] d;
        logic [NS-1:0]   m;
        u  = W'($urandom);
        nx = {u, path_st[SB-1:W]};
        d  = rand_dec();
        d[nx*W +: W] = path_st[W-1:0];
        for (int s = 0; s < NS; s++) m[s] = (($urandom % 100) >= purge_pct);
        m[nx] = 1'b1;
        step(1'b1, d, m, nx, tag);
        acc++;
        u_hist[acc] = u;
        path_st = nx;
        if (acc > L) check({tag, " path delay"}, int'(out_sym), int'(u_hist[acc-L]));
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_clear();
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset out_sym", int'(out_sym), 0);
    endtask

    task automatic t_fill();
        for (int k = 1; k <= L; k++) begin
            path_step(0, "R7 fill");
            check("R7 not yet valid", int'(out_valid), 0);
        end
        path_step(0, "R7 first");
        check("R7 first valid", int'(out_valid), 1);
        check("R1 cleared rows give path symbol", int'(out_sym), int'(u_hist[1]));
    endtask

    task automatic t_path_purge();
        for (int k = 0; k < 200; k++) path_step(60, "R5 R6 path purge");
    endtask

    task automatic t_idle_gaps();
        for (int k = 0; k < 150; k++) begin
            if (($urandom % 3) == 0)
                step(1'b0, rand_dec(), NS'({$urandom, $urandom}), SB'($urandom), "R2 idle");
            else
                path_step(30, "R2 after idle");
        end
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++)
            step(1'b1, rand_dec(), NS'({$urandom, $urandom}), SB'($urandom), "R3 R4 random");
        // random traffic breaks path continuity; restart it from the model view
    endtask

    task automatic t_mid_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        check("R8 reset out_valid", int'(out_valid), 0);
        for (int k = 1; k <= L; k++) begin
            path_step(20, "R8 refill");
            check("R8 no output during refill", int'(out_valid), 0);
        end
        for (int k = 0; k < 60; k++) path_step(20, "R8 after refill");
    endtask

    initial begin
        t_reset();
        t_fill();
        t_path_purge();
        t_idle_gaps();
        t_random();
        t_mid_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule